// File: doc/BRIEF.md
# SAR Conversion Sequencer with Early Interrupt

This block controls a 12-bit successive-approximation converter whose analog front end follows the input at all times. Because the input is always being followed, no acquisition window is needed. A trigger pulse starts a conversion at once, with no software involvement. The sequencer then resolves one bit per conversion clock, from the most significant bit down. Each cycle it presents a trial code to the DAC and uses the comparator answer to keep or drop that bit. After the last decision the finished code is copied into the result register, and a one-cycle ready strobe marks the update.

Interrupt service has a fixed entry latency. To hide it, the interrupt can be raised a programmable number of conversion clocks, from zero to eight, before the result is ready. The handler then starts while the last bits are still being resolved. The interrupt stays pending until it is acknowledged. The comparator and DAC sit outside this block.

Top module: `sar_seq`

## Requirements
- R1: While reset is held, busy_o, ready_o, irq_o, result_o and dac_o are all zero.
- R2: A trig_i sampled high while busy_o is low starts a conversion: busy_o is high in the next cycle, and dac_o shows 0x800 (only bit 11 set) in that cycle.
- R3: One bit is decided per clock, from bit 11 down to bit 0. In each conversion cycle dac_o is the bits kept so far plus the current trial bit. The trial bit is kept when cmp_i is 1, which means the input is at or above dac_o.
- R4: busy_o stays high for exactly 12 cycles. When it falls, result_o holds the resolved code, which for an ideal comparator equals the input level clipped to 4095.
- R5: ready_o is high for exactly one cycle: the first cycle in which busy_o is low again. result_o changes only in that cycle.
- R6: A trig_i that arrives while busy_o is high has no effect. This includes the cycle of the final decision: the conversion finishes on time and no new one starts.
- R7: With a lead of 0, irq_o rises in the same cycle as ready_o.
- R8: With a lead L from 1 to 8, irq_o rises L cycles before ready_o.
- R9: A lead above 8 behaves as a lead of 8.
- R10: Once raised, irq_o stays high until irq_ack_i is sampled high, and it falls in the following cycle. If an acknowledge coincides with a new interrupt event, irq_o stays high.
- R11: lead_i is captured on the accepted trigger. Changing it during a conversion does not move that conversion's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Conversion start request |
| lead_i | input | 4 | Early-interrupt lead in conversion clocks (0 to 8, larger values saturate) |
| irq_ack_i | input | 1 | Clears the pending interrupt |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above dac_o |
| dac_o | output | 12 | Trial code driven to the DAC |
| busy_o | output | 1 | Conversion in progress |
| ready_o | output | 1 | One-cycle strobe when result_o updates |
| result_o | output | 12 | Latched conversion result |
| irq_o | output | 1 | Pending interrupt |

## Verification
The hardest case to reach is an acknowledge that lands in the same cycle as a new interrupt event. The new event must win, or the software would miss an interrupt. The bench sets the lead to zero so that the event falls on the final decision edge. It then drives the acknowledge in exactly that cycle, counting conversion clocks from the accepted trigger. A second case that is hard to reach is a trigger on the final decision edge. The bench places one there, plus one mid-conversion, and watches for a spurious restart after the ready strobe.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned LEAD_W = 4;
  typedef logic [LEAD_W-1:0] lead_t;

  // Clamp a requested interrupt lead to the supported maximum.
  function automatic lead_t clamp_lead(input lead_t req, input lead_t limit);
    return (req > limit) ? limit : req;
  endfunction
endpackage

// File: rtl/sar_step_ctr.sv
module sar_step_ctr #(
  parameter int unsigned STEPS = 12,
  parameter int unsigned CW    = $clog2(STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  output logic          busy_o,
  output logic          accept_o,
  output logic          last_o,
  output logic [CW-1:0] rem_o
);
  localparam logic [CW-1:0] STEPS_C = CW'(STEPS);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  assign accept_o = trig_i && !busy_o;
  assign last_o   = busy_o && (rem_o == ONE_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      rem_o  <= '0;
    end else if (accept_o) begin
      busy_o <= 1'b1;
      rem_o  <= STEPS_C;
    end else if (busy_o) begin
      rem_o <= rem_o - ONE_C;
      if (last_o) busy_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         step_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_o,
  output logic [W-1:0] code_o
);
  logic [W-1:0] kept_q;
  logic [W-1:0] trial_q;

  // Keep or drop the trial bit based on the comparator answer.
  function automatic logic [W-1:0] resolve(input logic [W-1:0] kept,
                                           input logic [W-1:0] trial,
                                           input logic         above);
    return above ? (kept | trial) : kept;
  endfunction

  assign dac_o  = kept_q | trial_q;
  assign code_o = resolve(kept_q, trial_q, cmp_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kept_q  <= '0;
      trial_q <= '0;
    end else if (start_i) begin
      kept_q  <= '0;
      trial_q <= {1'b1, {(W-1){1'b0}}};
    end else if (step_i) begin
      kept_q  <= code_o;
      trial_q <= trial_q >> 1;
    end
  end
endmodule

// File: rtl/sar_irq.sv
module sar_irq
  import sar_pkg::*;
#(
  parameter int unsigned CW       = 4,
  parameter int unsigned LEAD_MAX = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  lead_t         lead_i,
  input  logic          busy_i,
  input  logic [CW-1:0] rem_i,
  input  logic          ack_i,
  output logic          fire_o,
  output logic          irq_o
);
  localparam lead_t LIMIT = LEAD_W'(LEAD_MAX);
  lead_t lead_q;

  // Fire on the edge that leaves exactly lead_q decisions outstanding.
  assign fire_o = busy_i && (int'(rem_i) == int'(lead_q) + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (start_i) lead_q <= clamp_lead(lead_i, LIMIT);
      if (fire_o)     irq_o <= 1'b1;
      else if (ack_i) irq_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter int unsigned LEAD_MAX = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         trig_i,
  input  logic [3:0]   lead_i,
  input  logic         irq_ack_i,
  input  logic         cmp_i,
  output logic [W-1:0] dac_o,
  output logic         busy_o,
  output logic         ready_o,
  output logic [W-1:0] result_o,
  output logic         irq_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          accept_evt;
  logic          last_evt;
  logic          irq_fire;
  logic [CW-1:0] rem;
  logic [W-1:0]  code_final;

  sar_step_ctr #(.STEPS(W), .CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .busy_o(busy_o),
    .accept_o(accept_evt), .last_o(last_evt), .rem_o(rem)
  );

  sar_approx #(.W(W)) u_approx (
    .clk(clk), .rst_n(rst_n), .start_i(accept_evt), .step_i(busy_o),
    .cmp_i(cmp_i), .dac_o(dac_o), .code_o(code_final)
  );

  sar_irq #(.CW(CW), .LEAD_MAX(LEAD_MAX)) u_irq (
    .clk(clk), .rst_n(rst_n), .start_i(accept_evt), .lead_i(lead_i),
    .busy_i(busy_o), .rem_i(rem), .ack_i(irq_ack_i),
    .fire_o(irq_fire), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      ready_o  <= 1'b0;
    end else begin
      ready_o <= last_evt;
      if (last_evt) result_o <= code_final;
    end
  end
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         trig_i,
  input logic         irq_ack_i,
  input logic [W-1:0] dac_o,
  input logic         busy_o,
  input logic         ready_o,
  input logic [W-1:0] result_o,
  input logic         irq_o,
  input logic         irq_fire
);
  localparam logic [W-1:0] MSB_CODE = {1'b1, {(W-1){1'b0}}};

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && trig_i) |=> (busy_o && dac_o == MSB_CODE));

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> !busy_o);

  assert_fall_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ready_o);

  assert_ready_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> $stable(result_o));

  assert_fire_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fire |=> irq_o);

  assert_irq_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !irq_ack_i) |=> irq_o);

  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && !irq_fire) |=> !irq_o);
endmodule

bind sar_seq sar_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .irq_ack_i(irq_ack_i),
  .dac_o(dac_o), .busy_o(busy_o), .ready_o(ready_o), .result_o(result_o),
  .irq_o(irq_o), .irq_fire(irq_fire)
);

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic [3:0]  lead = 4'd0;
  logic        ack = 1'b0;
  logic        cmp;
  logic [11:0] dac;
  logic        busy;
  logic        ready;
  logic [11:0] result;
  logic        irq;
  int          vin = 0;

  int checks = 0;
  int errors = 0;
  int irq_at, ready_at, ready_n, busy_n, busy_late;
  int dac1, dac2, res_ready, res_end;
  bit irq_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Ideal comparator and DAC model.
  assign cmp = (vin >= int'(dac));

  sar_seq u_dut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .lead_i(lead),
    .irq_ack_i(ack), .cmp_i(cmp), .dac_o(dac), .busy_o(busy),
    .ready_o(ready), .result_o(result), .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // One conversion; k counts negedges after the trigger edge.
  task automatic run(input int vin_v, input int lead_v, input int chg_at,
                     input int chg_val, input int rt1, input int rt2, input int ack_at);
    @(negedge clk);
    vin = vin_v; lead = 4'(lead_v); trig = 1'b1;
    irq_at = -1; ready_at = -1; ready_n = 0; busy_n = 0; busy_late = 0;
    res_ready = -1;
    for (int k = 1; k <= 18; k++) begin
      @(negedge clk);
      trig = 1'b0; ack = 1'b0;
      if (busy) busy_n++;
      if (busy && k > 13) busy_late++;
      if (k == 1) dac1 = int'(dac);
      if (k == 2) dac2 = int'(dac);
      if (irq && irq_at < 0) irq_at = k;
      if (ready) begin
        ready_n++;
        if (ready_at < 0) ready_at = k;
        res_ready = int'(result);
      end
      if (k == chg_at) lead = 4'(chg_val);
      if (k == rt1 || k == rt2) trig = 1'b1;
      if (k == ack_at) ack = 1'b1;
    end
    irq_end = irq;
    res_end = int'(result);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !ready && !irq, "R1 flags", int'({busy, ready, irq}), 0);
    check(result == 12'd0 && dac == 12'd0, "R1 data", int'(result | dac), 0);
  endtask

  task automatic t_convert(input int v);
    int exp = (v > 4095) ? 4095 : v;
    int exp2 = ((v >= 2048) ? 2048 : 0) + 1024;
    clear_irq();
    run(v, 0, -1, 0, -1, -1, -1);
    check(dac1 == 2048, "R2 first trial code", dac1, 2048);
    check(dac2 == exp2, "R3 second trial code", dac2, exp2);
    check(busy_n == 12, "R4 busy length", busy_n, 12);
    check(res_ready == exp, "R4 result", res_ready, exp);
    check(ready_n == 1 && ready_at == 13, "R5 ready pulse", ready_at, 13);
    check(res_end == exp, "R5 result held", res_end, exp);
  endtask

  task automatic t_lead(input int l, input int eff, input string req);
    clear_irq();
    run(1000, l, -1, 0, -1, -1, -1);
    check(ready_at - irq_at == eff, req, ready_at - irq_at, eff);
  endtask

  task automatic t_retrig();
    clear_irq();
    run(3000, 0, -1, 0, 5, 12, -1);
    check(busy_n == 12 && busy_late == 0, "R6 no restart", busy_n + busy_late, 12);
    check(ready_at == 13 && res_ready == 3000, "R6 result", res_ready, 3000);
  endtask

  task automatic t_ack();
    clear_irq();
    run(500, 2, -1, 0, -1, -1, -1);
    check(irq_end == 1'b1, "R10 pending held", int'(irq_end), 1);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    check(irq == 1'b0, "R10 cleared by ack", int'(irq), 0);
    run(500, 0, -1, 0, -1, -1, 12);
    check(irq_at == 13 && irq_end, "R10 event beats ack", irq_at, 13);
  endtask

  task automatic t_lead_change();
    clear_irq();
    run(777, 3, 2, 0, -1, -1, -1);
    check(ready_at - irq_at == 3, "R11 lead captured", ready_at - irq_at, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_convert(0);
    t_convert(4095);
    t_convert(2048);
    t_convert(2047);
    t_convert(1365);
    t_convert(5000);
    t_lead(0, 0, "R7 lead zero");
    for (int l = 1; l <= 8; l++) t_lead(l, l, "R8 lead");
    t_lead(12, 8, "R9 saturation");
    t_lead(15, 8, "R9 saturation max");
    t_retrig();
    t_ack();
    t_lead_change();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule